// File: doc/BRIEF.md
# Period and Pulse-Width Measurement Arbiter

This block measures, one channel at a time, the period and the pulse width of several input signals. The time base is a free-running timer counter that sits outside the block and advances on a prescaled tick. Each channel selects its reference edge, rising or falling. The period is the number of ticks between two reference edges. The pulse width is the number of ticks from a reference edge to the next opposite edge. When a measurement finishes, both values are written to that channel's capture registers and a one-cycle done event is raised.

Channels ask for measurement through a per-channel request input. A fixed-priority arbiter gives the measurement engine to the lowest-numbered requester. The engine keeps that channel until its measurement completes, times out, or loses its request. A timeout occurs when the shared counter reaches the target value before the measurement completes. A timeout raises a separate one-cycle flag and leaves the capture registers unchanged.

The engine has four states:
- IDLE: no channel holds the engine.
- ARM: waiting for the first reference edge.
- WIDTH: waiting for the opposite edge.
- PERIOD: waiting for the closing reference edge.

It takes six transitions:
- GRANT: IDLE to ARM.
- START: ARM to WIDTH.
- MARK: WIDTH to PERIOD.
- DONE: PERIOD to WIDTH when the same channel wins again, or PERIOD to ARM when another channel wins.
- TIMEOUT: any busy state to IDLE.
- ABORT: any busy state to IDLE.

The block drives a restart output that the external counter must obey. On the clock edge that ends a cycle with restart high, the counter goes to zero. Otherwise it advances by one on each tick. Captured values are the counter value plus one, which is the elapsed tick count.

Top module: `period_width_meter`

## Requirements
- R1: After reset, all capture outputs are zero, no done or timeout flag is high, and restart is low while no channel requests.
- R2: With the reference edge set to rising (`fall_sel_i[n]`=0), channel n captures the period as the high plus low time in ticks, and the width as the high time in ticks.
- R3: With the reference edge set to falling (`fall_sel_i[n]`=1), channel n captures the period in ticks, and the width as the low time in ticks.
- R4: `done_o[n]` is high for exactly one cycle. It rises in the cycle after the tick that detects the closing reference edge, and the new `period_o`/`width_o` values of slice n appear in that same cycle.
- R5: `cnt_restart_o` is high, combinationally, in each cycle of a GRANT, START, DONE or TIMEOUT transition. It is therefore high in the cycle before every done event.
- R6: Among the requesting channels, the engine is given to the one with the lowest index.
- R7: Arbitration happens only in IDLE and at DONE. No request preempts a running measurement. A holder that is still the lowest requester measures back to back.
- R8: If a tick arrives while the counter equals `target_i` and the measurement has not completed, `tmo_o[n]` pulses for one cycle, no done is raised, and the capture registers of n keep their values.
- R9: If the active channel drops its request, the measurement is abandoned. No done, no restart, and no capture update follow.
- R10: The shortest valid input, a period of 2 ticks with 1-tick phases, is measured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled tick strobe, one cycle wide |
| sig_i | input | NCH | Asynchronous signals under measurement, bit n is channel n |
| fall_sel_i | input | NCH | Reference edge per channel: 0 rising, 1 falling |
| req_i | input | NCH | Measurement request per channel |
| cnt_i | input | CW | Current value of the shared timer counter |
| target_i | input | CW | Counter value that ends a measurement by timeout |
| cnt_restart_o | output | 1 | Counter restart request, same cycle |
| period_o | output | NCH*CW | Captured period per channel, slice n at [n*CW +: CW] |
| width_o | output | NCH*CW | Captured width per channel, slice n at [n*CW +: CW] |
| done_o | output | NCH | One-cycle measurement-complete event per channel |
| tmo_o | output | NCH | One-cycle timeout flag per channel |

## Verification
A change on `sig_i` passes through two synchronizer flops. It is then seen on the first tick that follows, and the bench drives its signal edges aligned to ticks, so every edge carries the same detection delay. Done, timeout and the capture values are registered and appear one cycle after the deciding tick. Restart is combinational and appears in the deciding cycle itself. The bench samples on falling clock edges and polls for done or timeout, with a cycle limit. When an event is seen, the bench reads the capture values in that same sample. It compares them with tick counts worked out from its own generator settings. The bench also keeps the restart value from the previous falling edge, to check the one-cycle lead of R5.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_WIDTH,
        ST_PERIOD
    } meas_state_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_GRANT,
        ACT_START,
        ACT_MARK,
        ACT_DONE,
        ACT_TIMEOUT,
        ACT_ABORT
    } meas_act_t;

endpackage

// File: rtl/pm_sync_edge.sv
module pm_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sig_i,
    input  logic fall_sel_i,
    output logic ref_edge_o,
    output logic opp_edge_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              lvl_q;
    logic              primed_q;
    logic              synced;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= '0;
            lvl_q    <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[TOP-1:0], sig_i};
            if (tick_i) begin
                lvl_q    <= synced;
                primed_q <= 1'b1;
            end
        end
    end

    // the first tick after reset only loads the level, it reports no edge
    assign synced = sync_q[TOP];
    assign rise   = tick_i & primed_q &  synced & ~lvl_q;
    assign fall   = tick_i & primed_q & ~synced &  lvl_q;

    assign ref_edge_o = fall_sel_i ? fall : rise;
    assign opp_edge_o = fall_sel_i ? rise : fall;

endmodule

// File: rtl/pm_prio_pick.sv
module pm_prio_pick #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic [NCH-1:0] req_i,
    output logic           any_o,
    output logic [IW-1:0]  idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/pm_seq_fsm.sv
module pm_seq_fsm
    import pwm_meas_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int IW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic [NCH-1:0] req_i,
    input  logic           any_req_i,
    input  logic [IW-1:0]  win_idx_i,
    input  logic [NCH-1:0] ref_edge_i,
    input  logic [NCH-1:0] opp_edge_i,
    input  logic [CW-1:0]  cnt_i,
    input  logic [CW-1:0]  target_i,
    output logic [IW-1:0]  cur_idx_o,
    output logic           restart_o,
    output logic           width_stb_o,
    output logic           period_stb_o,
    output logic           tmo_stb_o
);
    meas_state_t state_q, state_d;
    meas_act_t   act;
    logic [IW-1:0] cur_q, cur_d;
    logic held, ref_hit, opp_hit, tmo_hit;

    assign held    = req_i[cur_q];
    assign ref_hit = ref_edge_i[cur_q];
    assign opp_hit = opp_edge_i[cur_q];
    assign tmo_hit = tick_i && (cnt_i == target_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        act     = ACT_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req_i) begin
                    state_d = ST_ARM;
                    cur_d   = win_idx_i;
                    act     = ACT_GRANT;
                end
            end
            ST_ARM: begin
                if (!held) begin
                    state_d = ST_IDLE;
                    act     = ACT_ABORT;
                end else if (ref_hit) begin
                    state_d = ST_WIDTH;
                    act     = ACT_START;
                end else if (tmo_hit) begin
                    state_d = ST_IDLE;
                    act     = ACT_TIMEOUT;
                end
            end
            ST_WIDTH: begin
                if (!held) begin
                    state_d = ST_IDLE;
                    act     = ACT_ABORT;
                end else if (opp_hit) begin
                    state_d = ST_PERIOD;
                    act     = ACT_MARK;
                end else if (tmo_hit) begin
                    state_d = ST_IDLE;
                    act     = ACT_TIMEOUT;
                end
            end
            ST_PERIOD: begin
                if (!held) begin
                    state_d = ST_IDLE;
                    act     = ACT_ABORT;
                end else if (ref_hit) begin
                    cur_d   = win_idx_i;
                    state_d = (win_idx_i == cur_q) ? ST_WIDTH : ST_ARM;
                    act     = ACT_DONE;
                end else if (tmo_hit) begin
                    state_d = ST_IDLE;
                    act     = ACT_TIMEOUT;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        restart_o    = 1'b0;
        width_stb_o  = 1'b0;
        period_stb_o = 1'b0;
        tmo_stb_o    = 1'b0;
        unique case (act)
            ACT_GRANT, ACT_START: restart_o = 1'b1;
            ACT_MARK:             width_stb_o = 1'b1;
            ACT_DONE: begin
                restart_o    = 1'b1;
                period_stb_o = 1'b1;
            end
            ACT_TIMEOUT: begin
                restart_o = 1'b1;
                tmo_stb_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign cur_idx_o = cur_q;

endmodule

// File: rtl/pm_capture_bank.sv
module pm_capture_bank #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int IW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     cur_idx_i,
    input  logic [CW-1:0]     cnt_i,
    input  logic              width_stb_i,
    input  logic              period_stb_i,
    input  logic              tmo_stb_i,
    output logic [NCH*CW-1:0] period_o,
    output logic [NCH*CW-1:0] width_o,
    output logic [NCH-1:0]    done_o,
    output logic [NCH-1:0]    tmo_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] ticks;
    logic [CW-1:0] width_hold_q;

    // the counter reads one less than the elapsed ticks at the deciding tick
    assign ticks = cnt_i + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_hold_q <= '0;
            period_o     <= '0;
            width_o      <= '0;
            done_o       <= '0;
            tmo_o        <= '0;
        end else begin
            if (width_stb_i) begin
                width_hold_q <= ticks;
            end
            for (int i = 0; i < NCH; i++) begin
                done_o[i] <= period_stb_i && (cur_idx_i == IW'(i));
                tmo_o[i]  <= tmo_stb_i && (cur_idx_i == IW'(i));
                if (period_stb_i && (cur_idx_i == IW'(i))) begin
                    period_o[i*CW +: CW] <= ticks;
                    width_o[i*CW +: CW]  <= width_hold_q;
                end
            end
        end
    end

endmodule

// File: rtl/period_width_meter.sv
module period_width_meter #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NCH-1:0]    sig_i,
    input  logic [NCH-1:0]    fall_sel_i,
    input  logic [NCH-1:0]    req_i,
    input  logic [CW-1:0]     cnt_i,
    input  logic [CW-1:0]     target_i,
    output logic              cnt_restart_o,
    output logic [NCH*CW-1:0] period_o,
    output logic [NCH*CW-1:0] width_o,
    output logic [NCH-1:0]    done_o,
    output logic [NCH-1:0]    tmo_o
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0] ref_edge;
    logic [NCH-1:0] opp_edge;
    logic           any_req;
    logic [IW-1:0]  win_idx;
    logic [IW-1:0]  cur_idx;
    logic           width_stb;
    logic           period_stb;
    logic           tmo_stb;

    for (genvar g = 0; g < NCH; g++) begin : g_edge
        pm_sync_edge #(.STAGES(2)) u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick_i),
            .sig_i      (sig_i[g]),
            .fall_sel_i (fall_sel_i[g]),
            .ref_edge_o (ref_edge[g]),
            .opp_edge_o (opp_edge[g])
        );
    end

    pm_prio_pick #(.NCH(NCH), .IW(IW)) u_pick (
        .req_i (req_i),
        .any_o (any_req),
        .idx_o (win_idx)
    );

    pm_seq_fsm #(.NCH(NCH), .CW(CW), .IW(IW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .req_i        (req_i),
        .any_req_i    (any_req),
        .win_idx_i    (win_idx),
        .ref_edge_i   (ref_edge),
        .opp_edge_i   (opp_edge),
        .cnt_i        (cnt_i),
        .target_i     (target_i),
        .cur_idx_o    (cur_idx),
        .restart_o    (cnt_restart_o),
        .width_stb_o  (width_stb),
        .period_stb_o (period_stb),
        .tmo_stb_o    (tmo_stb)
    );

    pm_capture_bank #(.NCH(NCH), .CW(CW), .IW(IW)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .cur_idx_i    (cur_idx),
        .cnt_i        (cnt_i),
        .width_stb_i  (width_stb),
        .period_stb_i (period_stb),
        .tmo_stb_i    (tmo_stb),
        .period_o     (period_o),
        .width_o      (width_o),
        .done_o       (done_o),
        .tmo_o        (tmo_o)
    );

endmodule

// File: rtl/pm_meas_checker.sv
module pm_meas_checker #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [NCH-1:0]    req_i,
    input logic [CW-1:0]     cnt_i,
    input logic [CW-1:0]     target_i,
    input logic              cnt_restart_o,
    input logic [NCH*CW-1:0] period_o,
    input logic [NCH*CW-1:0] width_o,
    input logic [NCH-1:0]    done_o,
    input logic [NCH-1:0]    tmo_o
);
    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o)); // R6

    AST_TMO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmo_o)); // R8

    AST_DONE_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_o) |-> $past(cnt_restart_o)); // R5

    AST_TMO_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmo_o) |-> $past(tick_i && (cnt_i == target_i))); // R8

    AST_CAPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(|done_o) |-> ($stable(period_o) && $stable(width_o))); // R4

    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_o & ~$past(req_i)) == '0)); // R9

endmodule

bind period_width_meter pm_meas_checker #(.NCH(NCH), .CW(CW)) u_meas_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .req_i         (req_i),
    .cnt_i         (cnt_i),
    .target_i      (target_i),
    .cnt_restart_o (cnt_restart_o),
    .period_o      (period_o),
    .width_o       (width_o),
    .done_o        (done_o),
    .tmo_o         (tmo_o)
);

// File: tb/tb_period_width_meter.sv
module tb_period_width_meter;
    localparam int NCH = 4;
    localparam int CW  = 16;
    localparam int DIV = 4;
    localparam int NV  = 6;
    // channel, falling reference, high ticks, low ticks, expected period, expected width
    localparam int VT [NV][6] = '{
        '{0, 0,  3,  5,   8,  3},
        '{1, 0, 10,  2,  12, 10},
        '{2, 1,  4,  7,  11,  7},
        '{3, 1,  1,  1,   2,  1},
        '{0, 1,  9,  3,  12,  3},
        '{1, 0, 50, 60, 110, 50}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [NCH-1:0]    sig = '0;
    logic [NCH-1:0]    fall_sel = '0;
    logic [NCH-1:0]    req = '0;
    logic [CW-1:0]     cnt = '0;
    logic [CW-1:0]     target = '1;
    logic              restart;
    logic [NCH*CW-1:0] per_o;
    logic [NCH*CW-1:0] wid_o;
    logic [NCH-1:0]    done;
    logic [NCH-1:0]    tmo;

    int total = 0;
    int fails = 0;
    int tdiv = 0;
    int gen_hi [NCH];
    int gen_lo [NCH];
    int gcnt   [NCH];
    bit gen_on [NCH];

    always #4 clk = ~clk;

    period_width_meter #(.NCH(NCH), .CW(CW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .sig_i         (sig),
        .fall_sel_i    (fall_sel),
        .req_i         (req),
        .cnt_i         (cnt),
        .target_i      (target),
        .cnt_restart_o (restart),
        .period_o      (per_o),
        .width_o       (wid_o),
        .done_o        (done),
        .tmo_o         (tmo)
    );

    // prescaled tick and counter model obeying the restart contract
    always_ff @(posedge clk) begin
        tdiv <= (tdiv == DIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == DIV - 1);
        if (restart)   cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // per-channel square-wave generator, edges aligned to ticks
    always_ff @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!gen_on[c]) begin
                sig[c]  <= 1'b0;
                gcnt[c] <= gen_lo[c];
            end else if (tick) begin
                if (gcnt[c] <= 1) begin
                    sig[c]  <= ~sig[c];
                    gcnt[c] <= sig[c] ? gen_lo[c] : gen_hi[c];
                end else begin
                    gcnt[c] <= gcnt[c] - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_done(input int ch, input int limit, output bit got, output int other);
        bit rprev;
        got = 1'b0;
        other = -1;
        rprev = 1'b0;
        for (int n = 0; n < limit && !got; n++) begin
            @(negedge clk);
            for (int k = 0; k < NCH; k++)
                if (done[k] && k != ch && other < 0) other = k;
            if (done[ch]) begin
                got = 1'b1;
                chk(rprev == 1'b1, "R5", rprev, 1);
            end
            rprev = restart;
        end
    endtask

    task automatic set_gen(input int ch, input int hi, input int lo, input bit on);
        gen_hi[ch] = hi;
        gen_lo[ch] = lo;
        gen_on[ch] = on;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        bit got;
        int other;
        int n1, n2;
        logic [CW-1:0] keep_p, keep_w;
        for (int c = 0; c < NCH; c++) set_gen(c, 4, 4, 1'b0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(per_o == '0, "R1", per_o, 0);
        chk(wid_o == '0, "R1", wid_o, 0);
        chk(done == '0, "R1", done, 0);
        chk(tmo == '0, "R1", tmo, 0);
        chk(restart == 1'b0, "R1", restart, 0);

        // vector table: R2, R3, R4, R10
        for (int v = 0; v < NV; v++) begin
            automatic int ch = VT[v][0];
            automatic string tag = (VT[v][4] == 2) ? "R10" : (VT[v][1] != 0) ? "R3" : "R2";
            fall_sel[ch] = VT[v][1][0];
            set_gen(ch, VT[v][2], VT[v][3], 1'b1);
            req[ch] = 1'b1;
            wait_done(ch, 3000, got, other);
            wait_done(ch, 3000, got, other);
            chk(got, tag, got, 1);
            chk(per_o[ch*CW +: CW] == CW'(VT[v][4]), tag, per_o[ch*CW +: CW], VT[v][4]);
            chk(wid_o[ch*CW +: CW] == CW'(VT[v][5]), tag, wid_o[ch*CW +: CW], VT[v][5]);
            @(negedge clk);
            chk(done[ch] == 1'b0, "R4", done[ch], 0);
            req[ch] = 1'b0;
            gen_on[ch] = 1'b0;
            repeat (8) @(negedge clk);
        end

        // R6: lowest requester first
        fall_sel = '0;
        set_gen(1, 3, 3, 1'b1);
        set_gen(2, 3, 3, 1'b1);
        req[1] = 1'b1;
        req[2] = 1'b1;
        wait_done(1, 1000, got, other);
        chk(got, "R6", got, 1);
        chk(other == -1, "R6", other, -1);
        // R7: holder keeps the engine while it is lowest
        n1 = 0;
        n2 = 0;
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            if (done[1]) n1++;
            if (done[2]) n2++;
        end
        chk(n1 >= 2, "R7", n1, 2);
        chk(n2 == 0, "R7", n2, 0);
        req[1] = 1'b0;
        wait_done(2, 1000, got, other);
        chk(got, "R7", got, 1);
        // R7: a new lower request does not preempt
        set_gen(0, 3, 3, 1'b1);
        req[0] = 1'b1;
        wait_done(2, 1000, got, other);
        chk(got && other == -1, "R7", other, -1);
        wait_done(0, 1000, got, other);
        chk(got && other == -1, "R6", other, -1);
        req = '0;
        for (int c = 0; c < NCH; c++) gen_on[c] = 1'b0;
        repeat (8) @(negedge clk);

        // R8: timeout leaves captures untouched
        keep_p = per_o[3*CW +: CW];
        keep_w = wid_o[3*CW +: CW];
        target = CW'(5);
        set_gen(3, 20, 20, 1'b1);
        req[3] = 1'b1;
        got = 1'b0;
        n1 = 0;
        for (int n = 0; n < 400 && !got; n++) begin
            @(negedge clk);
            if (tmo[3]) got = 1'b1;
            if (|done) n1++;
        end
        chk(got, "R8", got, 1);
        @(negedge clk);
        chk(tmo[3] == 1'b0, "R8", tmo[3], 0);
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            if (|done) n1++;
        end
        chk(n1 == 0, "R8", n1, 0);
        chk(per_o[3*CW +: CW] == keep_p, "R8", per_o[3*CW +: CW], keep_p);
        chk(wid_o[3*CW +: CW] == keep_w, "R8", wid_o[3*CW +: CW], keep_w);
        req[3] = 1'b0;
        gen_on[3] = 1'b0;
        target = '1;
        repeat (8) @(negedge clk);

        // R9: dropping the request abandons the measurement
        keep_p = per_o[0 +: CW];
        keep_w = wid_o[0 +: CW];
        fall_sel[0] = 1'b0;
        set_gen(0, 30, 30, 1'b1);
        req[0] = 1'b1;
        repeat (200) @(negedge clk);
        req[0] = 1'b0;
        n1 = 0;
        n2 = 0;
        for (int n = 0; n < 800; n++) begin
            @(negedge clk);
            if (|done) n1++;
            if (restart) n2++;
        end
        chk(n1 == 0, "R9", n1, 0);
        chk(n2 == 0, "R9", n2, 0);
        chk(per_o[0 +: CW] == keep_p && wid_o[0 +: CW] == keep_w, "R9", per_o[0 +: CW], keep_p);
        gen_on[0] = 1'b0;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule